// File: doc/BRIEF.md
# Two-Step Acquisition Lock Sequencer

This block decides which of two loops steers the oscillator of a clock-recovery circuit. A reference-based frequency loop pulls the oscillator near the target rate first, and a data-based phase loop then takes over to finish acquisition and track the incoming stream. The sequencer counts rising edges of the divided oscillator clock over a fixed number of reference cycles. It compares that count with the window length and hands control from one loop to the other.

The divided clock is counted in its own domain by a free-running counter. The count is Gray-coded and resynchronised into the reference domain with two flops. At every window boundary the reference side takes the difference between the current and the previous snapshot. Entry into phase tracking needs a tight match that holds over several consecutive windows. Leaving tracking needs a much larger error that also persists, so small wander during tracking never causes a handover. Each enable output is a separate register and changes only on the edge after a window closes. Exactly one loop is ever enabled.

Top module: `fa_lock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, before any decision, the frequency-loop enable is 1 and the phase-loop enable and lock flag are 0.
- R2: A measurement is the number of divided-clock rising edges seen in one window of WIN_LEN reference cycles. Its deviation is |count - WIN_LEN|.
- R3: In the frequency-loop state, CONFIRM consecutive windows with deviation <= ENTRY_TOL switch control to the phase loop.
- R4: In the frequency-loop state, any window with deviation > ENTRY_TOL restarts the entry streak. Alternating good and bad windows never switch.
- R5: In the phase-loop state, CONFIRM consecutive windows with deviation > EXIT_TOL return control to the frequency loop.
- R6: In the phase-loop state, a window with deviation <= EXIT_TOL restarts the exit streak. Deviations between ENTRY_TOL and EXIT_TOL, or a single bad window, keep the phase loop in control.
- R7: At every cycle exactly one of the two enables is 1, and the lock flag equals the phase-loop enable.
- R8: Enables change only at the reference rising edge numbered n*WIN_LEN+1 after reset release (n >= 1), which is the edge after a window's last cycle.
- R9: A stopped divided clock measures as deviation WIN_LEN. It therefore returns control to the frequency loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; defines the window and clocks all decisions |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| div_clk | input | 1 | Divided oscillator clock, asynchronous to ref_clk |
| freq_loop_en | output | 1 | 1 while the reference-based frequency loop steers the oscillator |
| phase_loop_en | output | 1 | 1 while the data-based phase loop steers the oscillator |
| locked | output | 1 | Lock flag; high exactly when the phase loop is enabled |

## Verification
Two events can land in the same reference cycle. One is a divided-clock edge whose Gray update is still settling in the synchroniser. The other is the window snapshot that reads the synchroniser. The bench sweeps the divided-clock period over a range of deviations either side of the target, so edges drift across every boundary position. Each sweep point is judged by the final loop selection, which has to follow the deviation thresholds whatever the edge phase. A second coincidence is a threshold decision and a streak restart falling in one window. The bench provokes it by switching the frequency right after a known boundary, so that single good and bad windows alternate. It then checks that no handover happens and that every enable change falls on an edge numbered n*WIN_LEN+1.

// File: rtl/fa_lock_pkg.sv
package fa_lock_pkg;

  typedef enum logic {
    LOOP_FREQ  = 1'b0,
    LOOP_PHASE = 1'b1
  } loop_sel_e;

  // distance of a window count from its nominal value
  function automatic int unsigned abs_dev(int unsigned cnt, int unsigned tgt);
    return (cnt >= tgt) ? (cnt - tgt) : (tgt - cnt);
  endfunction

  function automatic logic inside_tol(int unsigned dev, int unsigned tol);
    return (dev <= tol);
  endfunction

endpackage

// File: rtl/fa_gray_count.sv
module fa_gray_count #(
  parameter int W = 14
) (
  input  logic         div_clk,
  input  logic         rst_n,
  output logic [W-1:0] gray_o
);

  logic [W-1:0] bin_q;
  logic [W-1:0] bin_nxt;

  assign bin_nxt = bin_q + W'(1);

  always_ff @(posedge div_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_o <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

endmodule

// File: rtl/fa_gray_sync.sv
module fa_gray_sync #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_i;
      stab_q <= meta_q;
    end
  end

  always_comb begin
    bin_o[W-1] = stab_q[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ stab_q[i];
    end
  end

endmodule

// File: rtl/fa_window_meter.sv
module fa_window_meter
  import fa_lock_pkg::*;
#(
  parameter int WIN_LEN   = 4096,
  parameter int CW        = 14,
  parameter int ENTRY_TOL = 4,
  parameter int EXIT_TOL  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cur_bin,
  output logic          meas_valid,
  output logic [CW-1:0] meas_count,
  output logic          entry_hit,
  output logic          exit_hit
);

  localparam int WCW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WCW-1:0] LAST_CYC = WCW'(WIN_LEN - 1);

  logic [WCW-1:0] win_cnt;
  logic [CW-1:0]  prev_bin;
  logic           win_end;
  int unsigned    dev;

  assign win_end = (win_cnt == LAST_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt    <= '0;
      prev_bin   <= '0;
      meas_count <= '0;
      meas_valid <= 1'b0;
    end else begin
      meas_valid <= win_end;
      if (win_end) begin
        win_cnt    <= '0;
        meas_count <= cur_bin - prev_bin;
        prev_bin   <= cur_bin;
      end else begin
        win_cnt    <= win_cnt + WCW'(1);
      end
    end
  end

  assign dev       = abs_dev({{(32-CW){1'b0}}, meas_count}, WIN_LEN);
  assign entry_hit = meas_valid &&  inside_tol(dev, ENTRY_TOL);
  assign exit_hit  = meas_valid && !inside_tol(dev, EXIT_TOL);

  AST_WIN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid); // R2

  AST_BANDS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_hit && exit_hit)); // R6

endmodule

// File: rtl/fa_lock_fsm.sv
module fa_lock_fsm
  import fa_lock_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic meas_valid,
  input  logic entry_hit,
  input  logic exit_hit,
  output logic freq_en,
  output logic phase_en,
  output logic lock_flag
);

  localparam int SW = (CONFIRM > 1) ? $clog2(CONFIRM + 1) : 1;
  localparam logic [SW-1:0] LAST_STREAK = SW'(CONFIRM - 1);

  loop_sel_e     state_q, state_nxt;
  logic [SW-1:0] streak_q, streak_nxt;

  always_comb begin
    state_nxt  = state_q;
    streak_nxt = streak_q;
    if (meas_valid) begin
      unique case (state_q)
        LOOP_FREQ: begin
          if (!entry_hit) begin
            streak_nxt = '0;
          end else if (streak_q == LAST_STREAK) begin
            state_nxt  = LOOP_PHASE;
            streak_nxt = '0;
          end else begin
            streak_nxt = streak_q + SW'(1);
          end
        end
        LOOP_PHASE: begin
          if (!exit_hit) begin
            streak_nxt = '0;
          end else if (streak_q == LAST_STREAK) begin
            state_nxt  = LOOP_FREQ;
            streak_nxt = '0;
          end else begin
            streak_nxt = streak_q + SW'(1);
          end
        end
        default: state_nxt = LOOP_FREQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LOOP_FREQ;
      streak_q  <= '0;
      freq_en   <= 1'b1;
      phase_en  <= 1'b0;
      lock_flag <= 1'b0;
    end else begin
      state_q   <= state_nxt;
      streak_q  <= streak_nxt;
      freq_en   <= (state_nxt == LOOP_FREQ);
      phase_en  <= (state_nxt == LOOP_PHASE);
      lock_flag <= (state_nxt == LOOP_PHASE);
    end
  end

  AST_ONE_LOOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    freq_en ^ phase_en); // R7

  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_en) |-> $past(meas_valid)); // R8

  AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_en) |-> $past(entry_hit)); // R3

  AST_EXIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_en) |-> $past(exit_hit)); // R5

  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_en && meas_valid && !exit_hit) |=> phase_en); // R6

  AST_STAY_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_en && meas_valid && !entry_hit) |=> freq_en); // R4

endmodule

// File: rtl/fa_lock_ctrl.sv
module fa_lock_ctrl #(
  parameter int WIN_LEN   = 4096,
  parameter int ENTRY_TOL = 4,
  parameter int EXIT_TOL  = 16,
  parameter int CONFIRM   = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic div_clk,
  output logic freq_loop_en,
  output logic phase_loop_en,
  output logic locked
);

  // two spare bits: counts up to four times the window stay unaliased
  localparam int CW = $clog2(WIN_LEN) + 2;

  logic [CW-1:0] div_gray;
  logic [CW-1:0] div_bin_ref;
  logic          meas_valid;
  logic [CW-1:0] meas_count;
  logic          entry_hit;
  logic          exit_hit;

  fa_gray_count #(.W(CW)) u_cnt (
    .div_clk (div_clk),
    .rst_n   (rst_n),
    .gray_o  (div_gray)
  );

  fa_gray_sync #(.W(CW)) u_sync (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .gray_i (div_gray),
    .bin_o  (div_bin_ref)
  );

  fa_window_meter #(
    .WIN_LEN   (WIN_LEN),
    .CW        (CW),
    .ENTRY_TOL (ENTRY_TOL),
    .EXIT_TOL  (EXIT_TOL)
  ) u_meter (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .cur_bin    (div_bin_ref),
    .meas_valid (meas_valid),
    .meas_count (meas_count),
    .entry_hit  (entry_hit),
    .exit_hit   (exit_hit)
  );

  fa_lock_fsm #(.CONFIRM(CONFIRM)) u_fsm (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .entry_hit  (entry_hit),
    .exit_hit   (exit_hit),
    .freq_en    (freq_loop_en),
    .phase_en   (phase_loop_en),
    .lock_flag  (locked)
  );

  AST_LOCK_MATCHES_PHASE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    locked == phase_loop_en); // R7

  AST_RESET_RELEASE_FREQ: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(rst_n) |-> freq_loop_en); // R1

endmodule

// File: tb/fa_lock_ctrl_tb.sv
`timescale 1ps/1ps
module fa_lock_ctrl_tb;

  localparam int WIN   = 128;
  localparam int ENTRY = 3;
  localparam int EXIT  = 10;
  localparam int CONF  = 2;

  logic ref_clk = 1'b0;
  logic div_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic div_run = 1'b1;
  int   half_ps = 2000;
  logic freq_loop_en, phase_loop_en, locked;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  logic prev_phase = 1'b0;
  logic saw_rise   = 1'b0;
  logic saw_fall   = 1'b0;

  fa_lock_ctrl #(
    .WIN_LEN(WIN), .ENTRY_TOL(ENTRY), .EXIT_TOL(EXIT), .CONFIRM(CONF)
  ) u_dut (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .div_clk       (div_clk),
    .freq_loop_en  (freq_loop_en),
    .phase_loop_en (phase_loop_en),
    .locked        (locked)
  );

  always #2000 ref_clk = ~ref_clk;

  always begin
    if (div_run) begin
      div_clk = 1'b1; #(half_ps);
      div_clk = 1'b0; #(half_ps);
    end else begin
      div_clk = 1'b0; #(1000);
    end
  end

  always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  // continuous port monitor, sampled away from the active edge
  always @(negedge ref_clk) begin
    if (rst_n) begin
      chk("R7", freq_loop_en ^ phase_loop_en, 1'b1);
      chk("R7", locked, phase_loop_en);
      if (phase_loop_en !== prev_phase) begin
        chk("R8", ((cyc % WIN) == 1) && (cyc > WIN), 1'b1);
        if (phase_loop_en) saw_rise = 1'b1;
        else               saw_fall = 1'b1;
      end
    end
    prev_phase = phase_loop_en;
  end

  // divided clock rate giving a nominal count of WIN+d per window
  task automatic set_dev(int d);
    half_ps = (2000 * WIN) / (WIN + d);
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    chk("R1", freq_loop_en, 1'b1);
    chk("R1", phase_loop_en, 1'b0);
    chk("R1", locked, 1'b0);
    cyc = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_win(int n);
    repeat (n * WIN) @(negedge ref_clk);
  endtask

  task automatic align();
    while ((cyc % WIN) != 2) @(negedge ref_clk);
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  initial begin
    div_run = 1'b1;
    set_dev(0);

    // R1 just after release
    do_reset();
    @(negedge ref_clk);
    chk("R1", freq_loop_en, 1'b1);
    chk("R1", locked, 1'b0);

    // R2 / R3 sweep: entry from the frequency-loop state
    for (int d = -14; d <= 14; d++) begin
      if (iabs(d) == ENTRY || iabs(d) == ENTRY + 1) continue;
      set_dev(d);
      do_reset();
      wait_win(6);
      chk("R3", phase_loop_en, (iabs(d) <= ENTRY));
      chk("R2", freq_loop_en, (iabs(d) > ENTRY));
    end

    // R5 / R6 sweep: exit and hysteresis from the phase-loop state
    for (int d = -14; d <= 14; d++) begin
      if (iabs(d) == EXIT || iabs(d) == EXIT + 1) continue;
      set_dev(0);
      do_reset();
      wait_win(4);
      chk("R3", locked, 1'b1);
      set_dev(d);
      wait_win(6);
      if (iabs(d) <= EXIT) chk("R6", locked, 1'b1);
      else                 chk("R5", freq_loop_en, 1'b1);
    end

    // R4: alternating good and bad windows never hand over
    set_dev(14);
    do_reset();
    wait_win(2);
    align();
    saw_rise = 1'b0;
    for (int k = 0; k < 4; k++) begin
      set_dev(0);  wait_win(1);
      set_dev(14); wait_win(1);
    end
    wait_win(1);
    chk("R4", saw_rise, 1'b0);
    chk("R4", freq_loop_en, 1'b1);

    // R6: a single bad window while tracking
    set_dev(0);
    do_reset();
    wait_win(4);
    align();
    saw_fall = 1'b0;
    set_dev(14); wait_win(1);
    set_dev(0);  wait_win(4);
    chk("R6", saw_fall, 1'b0);
    chk("R6", locked, 1'b1);

    // R5: two bad windows drop, then R3 relocks
    align();
    saw_fall = 1'b0;
    set_dev(-14); wait_win(2);
    set_dev(0);   wait_win(4);
    chk("R5", saw_fall, 1'b1);
    chk("R3", locked, 1'b1);

    // R9: stopped divided clock
    div_run = 1'b0;
    wait_win(4);
    chk("R9", freq_loop_en, 1'b1);
    chk("R9", locked, 1'b0);
    div_run = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(64'd180000 * 64'd4000);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule